// File: doc/BRIEF.md
# Per-Port Flow Control and Backpressure Trigger

This block watches the buffer occupancy of a single switch port and decides when the remote sender has to be slowed down. In full-duplex operation it uses a two-threshold scheme. When occupancy climbs to the upper threshold, it asks the MAC to emit a PAUSE frame carrying the largest pause time. When occupancy sinks back to the lower threshold, it asks for a PAUSE frame with zero pause time so that the partner can resume. An XOFF flag provides hysteresis between the two thresholds. Only one request can be pending at a time, and the request stays up until the MAC acknowledges it.

In half-duplex operation the block instead raises a one-cycle jam request each time a frame starts arriving while occupancy is at or above the upper threshold. The jam forces a collision, which makes the remote station back off. The block also flags incoming frames that must be discarded because no buffer is free and backpressure cannot hold them off. In full-duplex mode it suppresses collision indications. Each scheme has its own enable strap. The two thresholds come up at fixed reset defaults and can be rewritten at configuration time.

Top module: `fcbp_trigger`

## Requirements
- R1: After a synchronous reset the upper threshold is 0x40, the lower threshold is 0x1C, and pause_req, jam_req, drop_frame and coll_out are all 0.
- R2: With full_duplex=1 and pause_en=1, if XOFF is clear, no request is pending and occupancy >= upper threshold, then one cycle later pause_req=1 and pause_time=0xFFFF, and XOFF is set.
- R3: With full_duplex=1 and pause_en=1, if XOFF is set, no request is pending and occupancy <= lower threshold, then one cycle later pause_req=1 and pause_time=0x0000, and XOFF is cleared.
- R4: No new PAUSE request is raised while XOFF is set and occupancy stays above the lower threshold. No new PAUSE request is raised while XOFF is clear and occupancy stays below the upper threshold.
- R5: A pending pause_req stays at 1 with an unchanged pause_time until a cycle in which pause_ack=1. It drops to 0 on the following cycle.
- R6: A change of full_duplex clears XOFF and any pending request; pause_req is 0 on the next cycle.
- R7: With full_duplex=0, bp_en=1, frame_start=1 and occupancy >= upper threshold, jam_req is 1 for exactly the following cycle. Otherwise jam_req is 0.
- R8: drop_frame is 1 on the cycle after a frame_start that arrives while buf_free=0, unless the port is half-duplex with bp_en=1.
- R9: coll_out follows coll_in with one cycle delay in half-duplex mode and is 0 whenever full_duplex was 1 on the previous cycle.
- R10: A cycle with cfg_wr=1 loads cfg_hi and cfg_lo as the new thresholds, and these govern R2, R3 and R7 from the next cycle on.
- R11: When pause_en=0 or full_duplex=0, no PAUSE request is raised and XOFF is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| full_duplex | input | 1 | 1 = full-duplex link, 0 = half-duplex |
| pause_en | input | 1 | Strap enabling PAUSE flow control |
| bp_en | input | 1 | Strap enabling half-duplex backpressure |
| cfg_wr | input | 1 | Load new thresholds |
| cfg_hi | input | OCC_W | New upper threshold |
| cfg_lo | input | OCC_W | New lower threshold |
| occupancy | input | OCC_W | Buffers in use for this port |
| buf_free | input | 1 | At least one free buffer exists |
| frame_start | input | 1 | One-cycle pulse when an incoming frame is sensed |
| coll_in | input | 1 | Collision indication from the line |
| pause_ack | input | 1 | MAC has taken the PAUSE request |
| pause_req | output | 1 | PAUSE frame requested |
| pause_time | output | PT_W | Pause value for the requested frame |
| jam_req | output | 1 | Jam the input port now |
| drop_frame | output | 1 | Discard the frame that just started |
| coll_out | output | 1 | Collision indication passed on to the MAC |

## Verification
The assertions assume that frame_start is a single-cycle pulse, that the duplex and strap inputs are stable across the cycles being judged, and that cfg_lo is below cfg_hi. The bench changes the straps and the duplex mode only between sequences. It raises pause_ack for one cycle and only while a request is pending. It keeps every programmed threshold pair ordered. Jam, drop and collision outputs are swept over all combinations of mode, strap, buffer and pulse inputs, with occupancy just below, at and above the threshold.

// File: rtl/fcbp_pkg.sv
package fcbp_pkg;
  localparam int DEF_XOFF_LEVEL = 'h40;
  localparam int DEF_XON_LEVEL  = 'h1C;
  localparam int PAUSE_FULL     = 'hFFFF;
endpackage

// File: rtl/fcbp_thresh_regs.sv
module fcbp_thresh_regs #(
  parameter int OCC_W = 12,
  parameter logic [OCC_W-1:0] HI_RST = OCC_W'(fcbp_pkg::DEF_XOFF_LEVEL),
  parameter logic [OCC_W-1:0] LO_RST = OCC_W'(fcbp_pkg::DEF_XON_LEVEL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [OCC_W-1:0] cfg_hi,
  input  logic [OCC_W-1:0] cfg_lo,
  output logic [OCC_W-1:0] th_hi,
  output logic [OCC_W-1:0] th_lo
);
  always_ff @(posedge clk) begin
    if (rst) begin
      th_hi <= HI_RST;
      th_lo <= LO_RST;
    end else if (cfg_wr) begin
      th_hi <= cfg_hi;
      th_lo <= cfg_lo;
    end
  end

  // R10: programmed levels appear on the next cycle
  assert_cfg_load_R10: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> (th_hi == $past(cfg_hi)) && (th_lo == $past(cfg_lo)));
endmodule

// File: rtl/fcbp_pause_ctrl.sv
module fcbp_pause_ctrl #(
  parameter int OCC_W = 12,
  parameter int PT_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             full_duplex,
  input  logic             pause_en,
  input  logic [OCC_W-1:0] occupancy,
  input  logic [OCC_W-1:0] th_hi,
  input  logic [OCC_W-1:0] th_lo,
  input  logic             pause_ack,
  output logic             pause_req,
  output logic [PT_W-1:0]  pause_time
);
  localparam logic [PT_W-1:0] PT_MAX = PT_W'(fcbp_pkg::PAUSE_FULL);

  logic duplex_q;
  logic xoff_q;
  logic mode_chg;
  logic active;

  assign mode_chg = (full_duplex != duplex_q);
  assign active   = full_duplex & pause_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      duplex_q   <= full_duplex;
      xoff_q     <= 1'b0;
      pause_req  <= 1'b0;
      pause_time <= '0;
    end else begin
      duplex_q <= full_duplex;
      if (mode_chg || !active) begin
        xoff_q    <= 1'b0;
        pause_req <= 1'b0;
      end else if (pause_req) begin
        if (pause_ack) pause_req <= 1'b0;
      end else if (!xoff_q && (occupancy >= th_hi)) begin
        pause_req  <= 1'b1;
        pause_time <= PT_MAX;
        xoff_q     <= 1'b1;
      end else if (xoff_q && (occupancy <= th_lo)) begin
        pause_req  <= 1'b1;
        pause_time <= '0;
        xoff_q     <= 1'b0;
      end
    end
  end

  // R5: request held, value frozen, until acknowledged
  assert_pause_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (pause_req && !pause_ack && active && !mode_chg) |=> (pause_req && $stable(pause_time)));
  // R2/R3: a fresh request carries the full value exactly when XOFF was entered
  assert_pause_value_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(pause_req) |-> ((pause_time == PT_MAX) == xoff_q));
  // R6/R11: nothing requested outside enabled full duplex
  assert_pause_gate_R11: assert property (@(posedge clk) disable iff (rst)
    (!active || mode_chg) |=> !pause_req);
endmodule

// File: rtl/fcbp_halfdup_ctrl.sv
module fcbp_halfdup_ctrl #(
  parameter int OCC_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             full_duplex,
  input  logic             bp_en,
  input  logic [OCC_W-1:0] occupancy,
  input  logic [OCC_W-1:0] th_hi,
  input  logic             buf_free,
  input  logic             frame_start,
  input  logic             coll_in,
  output logic             jam_req,
  output logic             drop_frame,
  output logic             coll_out
);
  logic bp_mode;
  assign bp_mode = !full_duplex && bp_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      jam_req    <= 1'b0;
      drop_frame <= 1'b0;
      coll_out   <= 1'b0;
    end else begin
      jam_req    <= bp_mode && frame_start && (occupancy >= th_hi);
      drop_frame <= frame_start && !buf_free && !bp_mode;
      coll_out   <= coll_in && !full_duplex;
    end
  end

  // R7: jam is never requested in full duplex
  assert_no_jam_full_R7: assert property (@(posedge clk) disable iff (rst)
    full_duplex |=> !jam_req);
  // R9: collisions masked in full duplex
  assert_coll_mask_R9: assert property (@(posedge clk) disable iff (rst)
    full_duplex |=> !coll_out);
  // R8: a frame is never both jammed and dropped
  assert_jam_drop_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(jam_req && drop_frame));
  // R7: jam lasts one cycle per start pulse
  assert_jam_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    (jam_req && !frame_start) |=> !jam_req);
endmodule

// File: rtl/fcbp_trigger.sv
module fcbp_trigger #(
  parameter int OCC_W = 12,
  parameter int PT_W  = 16,
  parameter logic [OCC_W-1:0] HI_RST = OCC_W'(fcbp_pkg::DEF_XOFF_LEVEL),
  parameter logic [OCC_W-1:0] LO_RST = OCC_W'(fcbp_pkg::DEF_XON_LEVEL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             full_duplex,
  input  logic             pause_en,
  input  logic             bp_en,
  input  logic             cfg_wr,
  input  logic [OCC_W-1:0] cfg_hi,
  input  logic [OCC_W-1:0] cfg_lo,
  input  logic [OCC_W-1:0] occupancy,
  input  logic             buf_free,
  input  logic             frame_start,
  input  logic             coll_in,
  input  logic             pause_ack,
  output logic             pause_req,
  output logic [PT_W-1:0]  pause_time,
  output logic             jam_req,
  output logic             drop_frame,
  output logic             coll_out
);
  logic [OCC_W-1:0] th_hi;
  logic [OCC_W-1:0] th_lo;

  fcbp_thresh_regs #(.OCC_W(OCC_W), .HI_RST(HI_RST), .LO_RST(LO_RST)) u_thr (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_hi(cfg_hi), .cfg_lo(cfg_lo),
    .th_hi(th_hi), .th_lo(th_lo)
  );

  fcbp_pause_ctrl #(.OCC_W(OCC_W), .PT_W(PT_W)) u_pause (
    .clk(clk), .rst(rst), .full_duplex(full_duplex), .pause_en(pause_en),
    .occupancy(occupancy), .th_hi(th_hi), .th_lo(th_lo), .pause_ack(pause_ack),
    .pause_req(pause_req), .pause_time(pause_time)
  );

  fcbp_halfdup_ctrl #(.OCC_W(OCC_W)) u_half (
    .clk(clk), .rst(rst), .full_duplex(full_duplex), .bp_en(bp_en),
    .occupancy(occupancy), .th_hi(th_hi), .buf_free(buf_free),
    .frame_start(frame_start), .coll_in(coll_in), .jam_req(jam_req),
    .drop_frame(drop_frame), .coll_out(coll_out)
  );

  // R1: outputs quiet on the first cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!pause_req && !jam_req && !drop_frame && !coll_out));
endmodule

// File: tb/fcbp_trigger_tb.sv
module fcbp_trigger_tb;
  localparam int OCC_W = 12;
  localparam int PT_W  = 16;

  logic clk = 0, rst = 1;
  logic full_duplex = 1, pause_en = 0, bp_en = 0, cfg_wr = 0;
  logic [OCC_W-1:0] cfg_hi = '0, cfg_lo = '0, occupancy = '0;
  logic buf_free = 1, frame_start = 0, coll_in = 0, pause_ack = 0;
  logic pause_req, jam_req, drop_frame, coll_out;
  logic [PT_W-1:0] pause_time;

  int nvec = 0, nerr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fcbp_trigger #(.OCC_W(OCC_W), .PT_W(PT_W)) u_dut (
    .clk(clk), .rst(rst), .full_duplex(full_duplex), .pause_en(pause_en),
    .bp_en(bp_en), .cfg_wr(cfg_wr), .cfg_hi(cfg_hi), .cfg_lo(cfg_lo),
    .occupancy(occupancy), .buf_free(buf_free), .frame_start(frame_start),
    .coll_in(coll_in), .pause_ack(pause_ack), .pause_req(pause_req),
    .pause_time(pause_time), .jam_req(jam_req), .drop_frame(drop_frame),
    .coll_out(coll_out)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, int act, int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // expect a pause request with given value, or none
  task automatic chk_pause(string req, bit exp_req, int exp_time);
    chk(req, int'(pause_req), int'(exp_req));
    if (exp_req) chk(req, int'(pause_time), exp_time);
  endtask

  task automatic ack();
    pause_ack = 1; tick(); pause_ack = 0;
    chk("R5 cleared after ack", int'(pause_req), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nerr++; nvec++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    int hi = 'h40, lo = 'h1C;
    repeat (3) tick();
    rst = 0;
    // R1: reset state
    chk("R1 pause_req", int'(pause_req), 0);
    chk("R1 jam_req", int'(jam_req), 0);
    chk("R1 drop_frame", int'(drop_frame), 0);
    chk("R1 coll_out", int'(coll_out), 0);

    // Half-duplex / jam / drop / collision sweep (R7, R8, R9, R1 default upper 0x40)
    for (int v = 0; v < 16; v++) begin
      for (int d = -1; d <= 1; d++) begin
        full_duplex = v[0]; bp_en = v[1]; buf_free = v[2]; coll_in = v[3];
        occupancy = OCC_W'(hi + d);
        frame_start = 1;
        tick();
        frame_start = 0;
        chk("R7 jam", int'(jam_req), int'(!v[0] && v[1] && (d >= 0)));
        chk("R8 drop", int'(drop_frame), int'(!v[2] && !(!v[0] && v[1])));
        chk("R9 coll", int'(coll_out), int'(v[3] && !v[0]));
        tick();
        chk("R7 jam one cycle", int'(jam_req), 0);
        chk("R8 no drop without start", int'(drop_frame), 0);
      end
    end
    coll_in = 0; buf_free = 1; bp_en = 0;

    // Full-duplex PAUSE sequencing with default levels
    full_duplex = 1; pause_en = 1; occupancy = OCC_W'(hi - 1);
    tick(); tick();
    chk_pause("R4 below upper no request", 0, 0);
    occupancy = OCC_W'(hi);
    tick();
    chk_pause("R2 xoff request at 0x40", 1, 'hFFFF);
    occupancy = OCC_W'(lo - 5);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk_pause("R5 held without ack", 1, 'hFFFF);
    end
    occupancy = 'h50;
    ack();
    tick(); tick();
    chk_pause("R4 no duplicate xoff", 0, 0);
    occupancy = OCC_W'(lo + 1);
    tick();
    chk_pause("R4 above lower no xon", 0, 0);
    occupancy = OCC_W'(lo);
    tick();
    chk_pause("R3 xon request at 0x1C", 1, 0);
    ack();
    occupancy = 'h10;
    tick(); tick();
    chk_pause("R4 no duplicate xon", 0, 0);

    // R6: duplex change clears XOFF and pending request
    occupancy = OCC_W'(hi);
    tick();
    chk_pause("R6 setup xoff", 1, 'hFFFF);
    full_duplex = 0;
    tick();
    chk_pause("R6 cleared by mode change", 0, 0);
    tick();
    chk_pause("R11 none in half duplex", 0, 0);
    full_duplex = 1;
    tick();
    chk_pause("R6 change cycle quiet", 0, 0);
    tick();
    chk_pause("R6 xoff re-armed", 1, 'hFFFF);
    ack();

    // R11: strap off
    pause_en = 0;
    for (int o = 0; o < 'h60; o += 8) begin
      occupancy = OCC_W'(o);
      tick();
      chk_pause("R11 disabled", 0, 0);
    end

    // R10: reprogrammed levels
    cfg_hi = 'h20; cfg_lo = 'h08; cfg_wr = 1;
    tick();
    cfg_wr = 0;
    pause_en = 1; occupancy = 'h1F;
    tick(); tick();
    chk_pause("R10 below new upper", 0, 0);
    occupancy = 'h20;
    tick();
    chk_pause("R10 xoff at new upper", 1, 'hFFFF);
    ack();
    occupancy = 'h09;
    tick();
    chk_pause("R10 above new lower", 0, 0);
    occupancy = 'h08;
    tick();
    chk_pause("R10 xon at new lower", 1, 0);
    ack();
    // R10: new upper level governs jam
    pause_en = 0; full_duplex = 0; bp_en = 1; occupancy = 'h20;
    frame_start = 1;
    tick();
    frame_start = 0;
    chk("R10 jam at new upper", int'(jam_req), 1);

    // R1: reset restores default levels
    rst = 1; tick(); rst = 0;
    occupancy = 'h3F; frame_start = 1;
    tick();
    frame_start = 0;
    chk("R1 default upper restored", int'(jam_req), 0);
    occupancy = 'h40; frame_start = 1;
    tick();
    frame_start = 0;
    chk("R1 default upper restored", int'(jam_req), 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule